// File: doc/BRIEF.md
# Audio Sample Data Word Formatter

This block sits behind a digital audio receiver's subframe decoder. Each decoded subframe arrives as a one-cycle strobe carrying a 24-bit sample, four status bits (parity error, validity, user, channel status) and a 2-bit preamble type. The block turns it into a 32-bit word in one of three layouts and places that word in a one-entry holding register for a bus or DMA reader.

A 2-bit layout select chooses sample-low (flags above the sample), sample-high (flags below the sample) or a packed layout that joins the upper 16 bits of two successive samples into one word. Four mask inputs force chosen flag fields to zero. The holding register has a full flag. When a completed word arrives while the register is full and unread, the block raises a sticky overrun flag. An optional channel-order mode discards subframes after a resynchronisation pulse until a channel A subframe arrives.

Top module: `sample_word_fmt`

## Requirements
- R1: With layout 0, the word is {2'b00, preamble[1:0], chstat, user, validity, parity_err, sample[23:0]}. The sample is in bits 23:0, the flags in bits 27:24 and the preamble in bits 29:28.
- R2: With layout 1, the word is {sample[23:0], 2'b00, preamble[1:0], chstat, user, validity, parity_err}. The sample is in bits 31:8 and parity error is in bit 0.
- R3: With layout 2, the first accepted subframe of a pair is stored and produces no word. The second subframe completes the word {second_sample[23:8], first_sample[23:8]}. The full flag rises only after the second subframe.
- R4: Layout 3 produces exactly the same word as layout 0.
- R5: In layouts 0 and 1, each mask input forces its field to zero. mask_par_i clears parity error, mask_val_i clears validity, mask_cu_i clears both channel status and user, and mask_pt_i clears the preamble field.
- R6: A completed word loads the holding register and sets full_o on the next edge. A rd_i pulse while full_o is high clears full_o on the next edge. A word that completes in the same cycle as such a read is loaded.
- R7: When a word completes while full_o is high and rd_i is low, the held word is kept, the new word is dropped and ovr_o is set. ovr_o stays high until an ovr_clr_i cycle that has no new overrun in it.
- R8: dma_req_o is high exactly when dma_en_i is high and full_o is high.
- R9: Preamble codes are 1 (block start, channel A), 2 (channel A), 3 (channel B) and 0 (none). A sync_i pulse drops any half-built pair and discards any subframe in the same cycle. While order_i is high, subframes after sync_i are discarded until one with code 1 or 2 is accepted.
- R10: After reset, data_o is zero and full_o, ovr_o and dma_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_vld_i | input | 1 | Subframe strobe |
| sample_i | input | 24 | Audio sample |
| par_err_i | input | 1 | Parity error bit |
| vbit_i | input | 1 | Validity bit |
| ubit_i | input | 1 | User bit |
| cbit_i | input | 1 | Channel status bit |
| pre_i | input | 2 | Preamble type code |
| sync_i | input | 1 | Resynchronisation pulse |
| fmt_i | input | 2 | Layout select |
| mask_par_i | input | 1 | Zero parity error field |
| mask_val_i | input | 1 | Zero validity field |
| mask_cu_i | input | 1 | Zero channel status and user fields |
| mask_pt_i | input | 1 | Zero preamble field |
| order_i | input | 1 | Channel-order mode enable |
| dma_en_i | input | 1 | DMA request enable |
| rd_i | input | 1 | Holding register read strobe |
| ovr_clr_i | input | 1 | Overrun clear |
| data_o | output | 32 | Held word |
| full_o | output | 1 | Holding register holds an unread word |
| ovr_o | output | 1 | Sticky overrun flag |
| dma_req_o | output | 1 | Transfer request |

## Verification
The bench uses the default parameters: a 24-bit sample and a 16-bit packed half, so the word is 32 bits wide. At these values the bench checks every layout position bit for bit against fixed constants, with every mask combination. It also covers the packed pairing across a resync, overrun with a read in the same cycle, and the drop of channel B subframes before the first channel A.

// File: rtl/swf_pkg.sv
package swf_pkg;
  typedef enum logic [1:0] {
    FMT_LOW    = 2'd0,
    FMT_HIGH   = 2'd1,
    FMT_PACK   = 2'd2,
    FMT_RSVD   = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    PRE_NONE  = 2'd0,
    PRE_BLOCK = 2'd1,
    PRE_CHA   = 2'd2,
    PRE_CHB   = 2'd3
  } pre_e;

  typedef struct packed {
    logic       cbit;
    logic       ubit;
    logic       vbit;
    logic       perr;
  } flags_t;

  typedef struct packed {
    logic       pt;
    logic       cu;
    logic       val;
    logic       par;
  } mask_t;
endpackage

// File: rtl/swf_pair_gather.sv
module swf_pair_gather
  import swf_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int HALF_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sub_vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [1:0]          pre_i,
  input  logic                sync_i,
  input  logic [1:0]          fmt_i,
  input  logic                order_i,
  output logic                load_o,
  output logic [HALF_W-1:0]   first_hi_o
);
  localparam int HI_LSB = SAMPLE_W - HALF_W;

  logic aligned_q, half_q;
  logic [HALF_W-1:0] first_q;
  logic is_cha, accept, packed_mode;

  assign is_cha      = (pre_i == PRE_BLOCK) || (pre_i == PRE_CHA);
  assign accept      = sub_vld_i && !sync_i && (!order_i || aligned_q || is_cha);
  assign packed_mode = (fmt_i == FMT_PACK);
  assign load_o      = accept && (!packed_mode || half_q);
  assign first_hi_o  = first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_q <= 1'b0;
      half_q    <= 1'b0;
      first_q   <= '0;
    end else if (sync_i) begin
      aligned_q <= 1'b0;
      half_q    <= 1'b0;
    end else if (accept) begin
      aligned_q <= 1'b1;
      if (packed_mode && !half_q) begin
        half_q  <= 1'b1;
        first_q <= sample_i[SAMPLE_W-1:HI_LSB];
      end else begin
        half_q  <= 1'b0;
      end
    end
  end

  // R9: in order mode the first subframe taken after sync is channel A
  p_first_is_cha_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && order_i && !aligned_q |-> is_cha);

  // R3: a packed word is only emitted on the second half of a pair
  p_pair_second_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o && packed_mode |-> half_q);

  p_sync_drops_half_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !half_q);
endmodule

// File: rtl/swf_word_build.sv
module swf_word_build
  import swf_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int HALF_W   = 16,
  parameter int WORD_W   = 32
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  flags_t              flags_i,
  input  logic [1:0]          pre_i,
  input  mask_t               mask_i,
  input  logic [1:0]          fmt_i,
  input  logic [HALF_W-1:0]   first_hi_i,
  output logic [WORD_W-1:0]   word_o
);
  localparam int HI_LSB = SAMPLE_W - HALF_W;
  localparam int META_W = WORD_W - SAMPLE_W;
  localparam int PAD_W  = META_W - 6;

  flags_t      fl;
  logic [1:0]  pt;
  logic [5:0]  meta;

  always_comb begin
    fl.perr = flags_i.perr & ~mask_i.par;
    fl.vbit = flags_i.vbit & ~mask_i.val;
    fl.ubit = flags_i.ubit & ~mask_i.cu;
    fl.cbit = flags_i.cbit & ~mask_i.cu;
    pt      = pre_i & {2{~mask_i.pt}};
    meta    = {pt, fl.cbit, fl.ubit, fl.vbit, fl.perr};
  end

  always_comb begin
    unique case (fmt_i)
      FMT_HIGH: word_o = {sample_i, {PAD_W{1'b0}}, meta};
      FMT_PACK: word_o = {{(WORD_W-2*HALF_W){1'b0}}, sample_i[SAMPLE_W-1:HI_LSB], first_hi_i};
      default:  word_o = {{PAD_W{1'b0}}, meta, sample_i};
    endcase
  end
endmodule

// File: rtl/swf_hold_reg.sv
module swf_hold_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic [WORD_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o
);
  logic [WORD_W-1:0] data_q;
  logic full_q, ovr_q, blocked;

  assign blocked = full_q && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ovr_q <= (ovr_q && !ovr_clr_i) || (load_i && blocked);
      if (load_i && !blocked) begin
        data_q <= word_i;
        full_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;

  // R7: an unread word is never replaced
  p_keep_unread_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !rd_i |=> $stable(data_q) && full_q);

  p_ovr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !ovr_clr_i |=> ovr_q);

  // R6: a read with no arriving word empties the register
  p_read_empties_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && full_q && !load_i |=> !full_q);

  p_load_fills_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> full_q);
endmodule

// File: rtl/sample_word_fmt.sv
module sample_word_fmt
  import swf_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int HALF_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sub_vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                par_err_i,
  input  logic                vbit_i,
  input  logic                ubit_i,
  input  logic                cbit_i,
  input  logic [1:0]          pre_i,
  input  logic                sync_i,
  input  logic [1:0]          fmt_i,
  input  logic                mask_par_i,
  input  logic                mask_val_i,
  input  logic                mask_cu_i,
  input  logic                mask_pt_i,
  input  logic                order_i,
  input  logic                dma_en_i,
  input  logic                rd_i,
  input  logic                ovr_clr_i,
  output logic [SAMPLE_W+7:0] data_o,
  output logic                full_o,
  output logic                ovr_o,
  output logic                dma_req_o
);
  localparam int WORD_W = SAMPLE_W + 8;

  logic              load;
  logic [HALF_W-1:0] first_hi;
  logic [WORD_W-1:0] word;
  flags_t            flags;
  mask_t             mask;

  assign flags = '{cbit: cbit_i, ubit: ubit_i, vbit: vbit_i, perr: par_err_i};
  assign mask  = '{pt: mask_pt_i, cu: mask_cu_i, val: mask_val_i, par: mask_par_i};

  swf_pair_gather #(.SAMPLE_W(SAMPLE_W), .HALF_W(HALF_W)) u_gather (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sub_vld_i  (sub_vld_i),
    .sample_i   (sample_i),
    .pre_i      (pre_i),
    .sync_i     (sync_i),
    .fmt_i      (fmt_i),
    .order_i    (order_i),
    .load_o     (load),
    .first_hi_o (first_hi)
  );

  swf_word_build #(.SAMPLE_W(SAMPLE_W), .HALF_W(HALF_W), .WORD_W(WORD_W)) u_build (
    .sample_i   (sample_i),
    .flags_i    (flags),
    .pre_i      (pre_i),
    .mask_i     (mask),
    .fmt_i      (fmt_i),
    .first_hi_i (first_hi),
    .word_o     (word)
  );

  swf_hold_reg #(.WORD_W(WORD_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .word_i    (word),
    .rd_i      (rd_i),
    .ovr_clr_i (ovr_clr_i),
    .data_o    (data_o),
    .full_o    (full_o),
    .ovr_o     (ovr_o)
  );

  assign dma_req_o = dma_en_i && full_o;

  // R7: overrun only ever rises while a word was pending
  p_ovr_needs_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(full_o));

  // R3: a lone first half never fills the register
  p_pack_no_early_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o && sub_vld_i && !sync_i && fmt_i == FMT_PACK && !load |=> !full_o || rd_i == 1'b0);
endmodule

// File: tb/sample_word_fmt_bench.sv
module sample_word_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_vld = 0, par_err = 0, vbit = 0, ubit = 0, cbit = 0;
  logic [23:0] sample = '0;
  logic [1:0]  pre = '0, fmt = '0;
  logic        sync = 0, m_par = 0, m_val = 0, m_cu = 0, m_pt = 0;
  logic        order = 0, dma_en = 0, rd = 0, ovr_clr = 0;
  logic [31:0] data;
  logic        full, ovr, dma_req;

  int checks = 0, errors = 0;
  string phase = "R10";
  bit finished = 0;

  // reference model state
  bit [31:0] e_data;
  bit        e_full, e_ovr, e_aligned, e_half;
  bit [15:0] e_first;

  always #4 clk = ~clk;

  sample_word_fmt u_sample_word_fmt (
    .clk_i(clk), .rst_ni(rst_n), .sub_vld_i(sub_vld), .sample_i(sample),
    .par_err_i(par_err), .vbit_i(vbit), .ubit_i(ubit), .cbit_i(cbit),
    .pre_i(pre), .sync_i(sync), .fmt_i(fmt), .mask_par_i(m_par),
    .mask_val_i(m_val), .mask_cu_i(m_cu), .mask_pt_i(m_pt), .order_i(order),
    .dma_en_i(dma_en), .rd_i(rd), .ovr_clr_i(ovr_clr),
    .data_o(data), .full_o(full), .ovr_o(ovr), .dma_req_o(dma_req)
  );

  function automatic bit [31:0] ref_word();
    bit [5:0] meta;
    meta = {pre & {2{~m_pt}}, cbit & ~m_cu, ubit & ~m_cu, vbit & ~m_val, par_err & ~m_par};
    if (fmt == 2'd1) return {sample, 2'b00, meta};
    return {2'b00, meta, sample};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_data = 0; e_full = 0; e_ovr = 0; e_aligned = 0; e_half = 0; e_first = 0;
    end else begin
      bit done;
      bit [31:0] w;
      done = 0; w = 0;
      if (sync) begin
        e_aligned = 0; e_half = 0;
      end else if (sub_vld && (!order || e_aligned || pre == 2'd1 || pre == 2'd2)) begin
        e_aligned = 1;
        if (fmt == 2'd2) begin
          if (!e_half) begin
            e_half = 1; e_first = sample[23:8];
          end else begin
            e_half = 0; w = {sample[23:8], e_first}; done = 1;
          end
        end else begin
          e_half = 0; w = ref_word(); done = 1;
        end
      end
      if (ovr_clr) e_ovr = 0;
      if (done && e_full && !rd) e_ovr = 1;
      else if (done) begin e_data = w; e_full = 1; end
      else if (rd) e_full = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(phase, "data", data, e_data);
      chk("R6", "full", full, e_full);
      chk("R7", "ovr", ovr, e_ovr);
      chk("R8", "dma_req", dma_req, dma_en & e_full);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    sub_vld = 0; rd = 0; sync = 0; ovr_clr = 0;
  endtask

  task automatic send(logic [23:0] s, logic [3:0] fl, logic [1:0] p);
    sample = s; {cbit, ubit, vbit, par_err} = fl; pre = p; sub_vld = 1;
    step();
  endtask

  task automatic rd_pulse();
    rd = 1; step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset data", data, 0);
    chk("R10", "reset flags", {full, ovr, dma_req}, 0);
    rst_n = 1;
    step();

    phase = "R1"; fmt = 0;
    send(24'hABCDEF, 4'b1111, 2'd3);
    @(negedge clk); chk("R1", "layout0 const", data, 32'h3FABCDEF);
    rd_pulse();
    for (int i = 0; i < 20; i++) begin
      send(24'($urandom), 4'($urandom), 2'($urandom)); rd_pulse();
    end

    phase = "R5";
    for (int m = 0; m < 16; m++) begin
      {m_pt, m_cu, m_val, m_par} = 4'(m);
      fmt = 2'(m & 1);
      send(24'h5A5A5A, 4'b1111, 2'd3); rd_pulse();
    end
    fmt = 0; {m_pt, m_cu, m_val, m_par} = 4'b1010;
    send(24'h000001, 4'b1111, 2'd2);
    @(negedge clk); chk("R5", "masked pt/val", data, 32'h0D000001);
    rd_pulse();
    {m_pt, m_cu, m_val, m_par} = 0;

    phase = "R2"; fmt = 1;
    send(24'h123456, 4'b0001, 2'd2);
    @(negedge clk); chk("R2", "layout1 const", data, 32'h12345621);
    rd_pulse();
    for (int i = 0; i < 20; i++) begin
      send(24'($urandom), 4'($urandom), 2'($urandom)); rd_pulse();
    end

    phase = "R4"; fmt = 3;
    send(24'h00FF00, 4'b1010, 2'd1);
    @(negedge clk); chk("R4", "layout3 as 0", data, 32'h1A00FF00);
    rd_pulse();
    for (int i = 0; i < 10; i++) begin
      send(24'($urandom), 4'($urandom), 2'($urandom)); rd_pulse();
    end

    phase = "R3"; fmt = 2;
    send(24'h1234AA, 4'b0, 2'd2);
    @(negedge clk); chk("R3", "no word after first half", full, 0);
    send(24'h5678BB, 4'b0, 2'd3);
    @(negedge clk); chk("R3", "packed word", data, 32'h56781234);
    rd_pulse();
    send(24'h111111, 4'b0, 2'd2);
    sync = 1; step();
    send(24'h222222, 4'b0, 2'd2);
    send(24'h333333, 4'b0, 2'd3);
    @(negedge clk); chk("R3", "pair after sync", data, 32'h33332222);
    rd_pulse();
    for (int i = 0; i < 20; i++) begin
      send(24'($urandom), 4'($urandom), 2'($urandom));
      if (i % 2 == 1) rd_pulse();
    end

    phase = "R7"; fmt = 0;
    send(24'hAAAAAA, 4'b0, 2'd2);
    send(24'hBBBBBB, 4'b0, 2'd3);
    @(negedge clk); chk("R7", "old word kept", data, 32'h20AAAAAA);
    chk("R7", "overrun set", ovr, 1);
    rd = 1; sample = 24'hCCCCCC; pre = 2'd2; sub_vld = 1; step();
    @(negedge clk); chk("R6", "read+load same cycle", data, 32'h20CCCCCC);
    chk("R6", "still full", full, 1);
    ovr_clr = 1; step();
    rd_pulse();
    @(negedge clk); chk("R6", "emptied", full, 0);

    phase = "R8"; dma_en = 1;
    send(24'h010203, 4'b0, 2'd2);
    @(negedge clk); chk("R8", "dma req on full", dma_req, 1);
    dma_en = 0; step();
    dma_en = 1; rd_pulse();
    @(negedge clk); chk("R8", "dma req off when empty", dma_req, 0);

    phase = "R9"; order = 1; dma_en = 0;
    sync = 1; step();
    send(24'h0B0B0B, 4'b0, 2'd3);
    send(24'h0C0C0C, 4'b0, 2'd0);
    @(negedge clk); chk("R9", "B dropped before A", full, 0);
    send(24'h0A0A0A, 4'b0, 2'd1);
    @(negedge clk); chk("R9", "A accepted", data, 32'h100A0A0A);
    rd_pulse();
    send(24'h0D0D0D, 4'b0, 2'd3);
    @(negedge clk); chk("R9", "B after alignment", data, 32'h300D0D0D);
    rd_pulse();
    for (int i = 0; i < 30; i++) begin
      if (i % 7 == 0) begin sync = 1; step(); end
      send(24'($urandom), 4'($urandom), 2'($urandom));
      if ($urandom % 2) rd_pulse();
    end

    repeat (3) step();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule